// File: doc/BRIEF.md
# Page-Addressed Flash Erase Sequencer

This block takes one erase request, given as a byte address and a byte length, and turns it into a series of erase commands for a serial flash that is organised in pages. It drives a byte-level SPI master, and frames every command with chip select. Page size, the page-address shift and the device size are configuration inputs, so one instance serves flashes with 256-byte or 264-byte pages.

Each request is first checked against the device size and against page alignment. The start and the length are then converted to a page index and a page count. At every step the sequencer chooses between an eight-page block erase and a single-page erase. It sends the command, then reads the flash status again and again until the ready bit is set. Consecutive status reads are separated by a programmable number of idle clock cycles. The host sees a busy level, a one-cycle done pulse when the work is complete, and a one-cycle error pulse when the request is rejected.

Top module: `flash_erase_seq`

## Requirements
- R1: A request with zero length produces a done pulse in the cycle after it is accepted. It produces no error and no SPI byte.
- R2: A request whose start plus length exceeds `dev_size` produces an error pulse and no SPI byte. A request that ends exactly at `dev_size` is legal.
- R3: A request whose start or length is not a whole multiple of `page_size` produces an error pulse and no SPI byte.
- R4: Each erase frame is four bytes sent within one chip-select window. The bytes are the opcode, flash address bits 23:16, flash address bits 15:8, and then 0x00. The flash address is the page index shifted left by `page_shift`.
- R5: The block-erase opcode 0x50 is chosen when the current page index is a multiple of 8 and at least 8 pages remain. In every other case the page-erase opcode 0x81 is chosen.
- R6: After a block erase, the page index advances by 8 and the remaining count drops by 8. After a page erase, both move by 1.
- R7: After each erase frame, the block sends status frames until it sees a ready status. A status frame is the byte 0xD7 followed by one byte that the block reads back. Status bit 7 set to 1 means ready; the other bits of the status are ignored. The next erase frame, or the completion, follows only the first ready status.
- R8: Before every status frame, chip select stays low for at least `poll_gap`+1 clock cycles.
- R9: `done` and `error` are single-cycle pulses and never occur together. `busy` is high from the cycle after an accepted erase until completion. Chip select is never active while `busy` is low. After reset, all outputs are low.
- R10: `req_valid` is ignored while `busy` is high. It changes neither the SPI traffic nor the completion.
- R11: `spi_req` is high only while `spi_cs` is high. `spi_tx` is held stable until `spi_ack` accepts the byte. `spi_rx` is taken in the cycle of `spi_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request strobe, taken when not busy |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| page_size | input | PS_W | Bytes per page (nonzero) |
| page_shift | input | SH_W | Left shift applied to the page index to form the flash address |
| dev_size | input | ADDR_W | Device size in bytes |
| poll_gap | input | GAP_W | Idle cycles before each status frame |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |
| spi_cs | output | 1 | Chip select, active high, frames one command |
| spi_req | output | 1 | Byte to send is valid |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Byte accepted by the SPI master |
| spi_rx | input | 8 | Byte received, valid with spi_ack |

## Verification
Two events can coincide: a fresh host request and an erase that is still running. This covers a request that arrives between frames, or in the middle of status polling. The bench provokes this by pulsing `req_valid` with different parameters while `busy` is high, and with the SPI acknowledge arriving at random delays. It judges the result by checking that the recorded erase frames still match the list computed for the original request, and that exactly one done pulse appears.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_STATUS      = 8'hD7;

  typedef enum logic [2:0] {
    S_IDLE, S_DIVA, S_DIVL, S_PREP, S_CMD, S_GAP, S_POLL
  } seq_state_t;
endpackage

// File: rtl/flash_erase_div.sv
module flash_erase_div #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quo,
  output logic [NUM_W-1:0] rem
);
  logic             run;
  logic [NUM_W-1:0] den_ext;

  assign den_ext = NUM_W'(den);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      fin <= 1'b0;
      quo <= '0;
      rem <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        run <= 1'b1;
        quo <= '0;
        rem <= num;
      end else if (run) begin
        if (den_ext != '0 && rem >= den_ext) begin
          rem <= rem - den_ext;
          quo <= quo + 1'b1;
        end else begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  AST_DIV_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    (fin && den_ext != '0) |-> (rem < den_ext)); // R3
endmodule

// File: rtl/flash_erase_step.sv
module flash_erase_step
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SH_W      = 4,
  parameter int BLK_PAGES = 8
) (
  input  logic [ADDR_W-1:0] page_idx,
  input  logic [ADDR_W-1:0] pages_left,
  input  logic [SH_W-1:0]   shift,
  input  logic [1:0]        byte_sel,
  output logic              is_block,
  output logic [7:0]        frame_byte,
  output logic [ADDR_W-1:0] next_idx,
  output logic [ADDR_W-1:0] next_left
);
  localparam int BLK_LG = $clog2(BLK_PAGES);

  logic [23:0]       flash_addr;
  logic [ADDR_W-1:0] stride;

  assign is_block   = (page_idx[BLK_LG-1:0] == '0) && (pages_left >= ADDR_W'(BLK_PAGES));
  assign stride     = is_block ? ADDR_W'(BLK_PAGES) : ADDR_W'(1);
  assign next_idx   = page_idx + stride;
  assign next_left  = pages_left - stride;
  assign flash_addr = 24'(page_idx << shift);

  always_comb begin
    case (byte_sel)
      2'd0:    frame_byte = is_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
      2'd1:    frame_byte = flash_addr[23:16];
      2'd2:    frame_byte = flash_addr[15:8];
      default: frame_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PS_W   = 12,
  parameter int SH_W   = 4,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  input  logic [PS_W-1:0]   page_size,
  input  logic [SH_W-1:0]   page_shift,
  input  logic [ADDR_W-1:0] dev_size,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              spi_cs,
  output logic              spi_req,
  output logic [7:0]        spi_tx,
  input  logic              spi_ack,
  input  logic [7:0]        spi_rx
);
  localparam int BLK_PAGES = 8;

  seq_state_t        state;
  logic [PS_W-1:0]   ps_q;
  logic [SH_W-1:0]   sh_q;
  logic [GAP_W-1:0]  gap_q, gap_cnt;
  logic [ADDR_W-1:0] len_q, idx_q, left_q;
  logic [1:0]        bsel;
  logic              div_start, div_fin;
  logic [ADDR_W-1:0] div_num, div_quo, div_rem;
  logic              step_blk;
  logic [7:0]        step_byte;
  logic [ADDR_W-1:0] step_nidx, step_nleft;
  logic              out_of_range;

  assign out_of_range = ({1'b0, req_addr} + {1'b0, req_len}) > {1'b0, dev_size};
  assign bsel = (state == S_CMD) ? bsel_q + 2'd1 : 2'd0;

  logic [1:0] bsel_q;

  flash_erase_div #(.NUM_W(ADDR_W), .DEN_W(PS_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(ps_q),
    .fin(div_fin), .quo(div_quo), .rem(div_rem)
  );

  flash_erase_step #(.ADDR_W(ADDR_W), .SH_W(SH_W), .BLK_PAGES(BLK_PAGES)) u_step (
    .page_idx(idx_q), .pages_left(left_q), .shift(sh_q), .byte_sel(bsel),
    .is_block(step_blk), .frame_byte(step_byte),
    .next_idx(step_nidx), .next_left(step_nleft)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      spi_cs    <= 1'b0;
      spi_req   <= 1'b0;
      spi_tx    <= 8'h00;
      ps_q      <= '0;
      sh_q      <= '0;
      gap_q     <= '0;
      gap_cnt   <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      left_q    <= '0;
      bsel_q    <= 2'd0;
      div_start <= 1'b0;
      div_num   <= '0;
    end else begin
      done      <= 1'b0;
      error     <= 1'b0;
      div_start <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            ps_q  <= page_size;
            sh_q  <= page_shift;
            gap_q <= poll_gap;
            len_q <= req_len;
            if (req_len == '0) begin
              done <= 1'b1;
            end else if (out_of_range) begin
              error <= 1'b1;
            end else begin
              busy      <= 1'b1;
              div_start <= 1'b1;
              div_num   <= req_addr;
              state     <= S_DIVA;
            end
          end
        end
        S_DIVA: begin
          if (div_fin) begin
            if (div_rem != '0) begin
              error <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              idx_q     <= div_quo;
              div_start <= 1'b1;
              div_num   <= len_q;
              state     <= S_DIVL;
            end
          end
        end
        S_DIVL: begin
          if (div_fin) begin
            if (div_rem != '0) begin
              error <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              left_q <= div_quo;
              state  <= S_PREP;
            end
          end
        end
        S_PREP: begin
          spi_cs  <= 1'b1;
          spi_req <= 1'b1;
          spi_tx  <= step_byte;
          bsel_q  <= 2'd0;
          state   <= S_CMD;
        end
        S_CMD: begin
          if (spi_ack) begin
            if (bsel_q == 2'd3) begin
              spi_cs  <= 1'b0;
              spi_req <= 1'b0;
              gap_cnt <= gap_q;
              state   <= S_GAP;
            end else begin
              bsel_q <= bsel_q + 2'd1;
              spi_tx <= step_byte;
            end
          end
        end
        S_GAP: begin
          if (gap_cnt == '0) begin
            spi_cs  <= 1'b1;
            spi_req <= 1'b1;
            spi_tx  <= OP_STATUS;
            bsel_q  <= 2'd0;
            state   <= S_POLL;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        S_POLL: begin
          if (spi_ack) begin
            if (bsel_q == 2'd0) begin
              bsel_q <= 2'd1;
              spi_tx <= 8'h00;
            end else begin
              spi_cs  <= 1'b0;
              spi_req <= 1'b0;
              if (spi_rx[7]) begin
                idx_q  <= step_nidx;
                left_q <= step_nleft;
                if (step_nleft == '0) begin
                  done  <= 1'b1;
                  busy  <= 1'b0;
                  state <= S_IDLE;
                end else begin
                  state <= S_PREP;
                end
              end else begin
                gap_cnt <= gap_q;
                state   <= S_GAP;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_ERR_APART: assert property (@(posedge clk) disable iff (rst)
    !(done && error)); // R9
  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_cs); // R9
  AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    spi_req |-> spi_cs); // R11
  AST_TX_HELD: assert property (@(posedge clk) disable iff (rst)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx))); // R11
  AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (spi_req && spi_tx == OP_BLOCK_ERASE && state == S_CMD && bsel_q == 2'd0)
      |-> (idx_q[2:0] == 3'd0)); // R5
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int ADDR_W = 24;
  localparam int PS_W   = 12;
  localparam int SH_W   = 4;
  localparam int GAP_W  = 8;
  localparam int MAXF   = 128;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [ADDR_W-1:0] req_len = '0;
  logic [PS_W-1:0]   page_size = 12'd264;
  logic [SH_W-1:0]   page_shift = 4'd9;
  logic [ADDR_W-1:0] dev_size = '0;
  logic [GAP_W-1:0]  poll_gap = 8'd2;
  logic              busy, done, error, spi_cs, spi_req;
  logic [7:0]        spi_tx;
  logic              spi_ack = 1'b0;
  logic [7:0]        spi_rx = 8'h00;

  always #5 clk = ~clk;

  flash_erase_seq #(.ADDR_W(ADDR_W), .PS_W(PS_W), .SH_W(SH_W), .GAP_W(GAP_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .page_size(page_size), .page_shift(page_shift), .dev_size(dev_size), .poll_gap(poll_gap),
    .busy(busy), .done(done), .error(error), .spi_cs(spi_cs), .spi_req(spi_req),
    .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // flash and SPI master model
  logic       tst_clear = 1'b0;
  int         fidx, nbytes, nframes, ndone, viol_busy, viol_gap, lowrun, busyleft;
  logic       ready_ok, prev_cs;
  logic [7:0] cur_op, cur_b1, cur_b2;
  logic [7:0] rec_op [0:MAXF-1];
  logic [7:0] rec_b1 [0:MAXF-1];
  logic [7:0] rec_b2 [0:MAXF-1];
  logic [7:0] rec_b3 [0:MAXF-1];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    prev_cs <= spi_cs;
    if (rst || tst_clear) begin
      spi_ack <= 1'b0; fidx <= 0; nbytes <= 0; nframes <= 0; ndone <= 0;
      viol_busy <= 0; viol_gap <= 0; lowrun <= 0; busyleft <= 0; ready_ok <= 1'b1;
    end else begin
      if (done) ndone <= ndone + 1;
      if (!spi_cs) lowrun <= lowrun + 1;
      else if (!prev_cs) begin
        if (spi_tx == 8'hD7 && lowrun < int'(poll_gap) + 1) viol_gap <= viol_gap + 1;
        lowrun <= 0;
      end
      spi_ack <= 1'b0;
      if (!spi_cs) fidx <= 0;
      else if (spi_req && !spi_ack && ($urandom % 3 != 0)) begin
        spi_ack <= 1'b1;
        spi_rx  <= 8'($urandom);
        nbytes  <= nbytes + 1;
        fidx    <= fidx + 1;
        case (fidx)
          0: begin
            cur_op <= spi_tx;
            if (spi_tx != 8'hD7) begin
              if (!ready_ok) viol_busy <= viol_busy + 1;
              ready_ok <= 1'b0;
              busyleft <= int'($urandom % 3);
            end else if (ready_ok) viol_busy <= viol_busy + 1;
          end
          1: begin
            cur_b1 <= spi_tx;
            if (cur_op == 8'hD7) begin
              if (busyleft == 0) begin
                spi_rx <= 8'h80 | 8'($urandom % 128);
                ready_ok <= 1'b1;
              end else begin
                spi_rx <= 8'($urandom % 128);
                busyleft <= busyleft - 1;
              end
            end
          end
          2: cur_b2 <= spi_tx;
          3: begin
            if (nframes < MAXF) begin
              rec_op[nframes] <= cur_op; rec_b1[nframes] <= cur_b1;
              rec_b2[nframes] <= cur_b2; rec_b3[nframes] <= spi_tx;
            end
            nframes <= nframes + 1;
          end
          default: ;
        endcase
      end
    end
  end

  // expected frames
  int         exp_n;
  logic [7:0] exp_op [0:MAXF-1];
  logic [7:0] exp_b1 [0:MAXF-1];
  logic [7:0] exp_b2 [0:MAXF-1];

  task automatic build_exp(input int p, input int n, input int sh);
    logic [23:0] fa;
    exp_n = 0;
    while (n > 0) begin
      automatic bit blk = (p % 8 == 0) && (n >= 8);
      fa = 24'(p << sh);
      exp_op[exp_n] = blk ? 8'h50 : 8'h81;
      exp_b1[exp_n] = fa[23:16];
      exp_b2[exp_n] = fa[15:8];
      exp_n++;
      p += blk ? 8 : 1;
      n -= blk ? 8 : 1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic string req_tag(int kind);
    case (kind)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R9";
    endcase
  endfunction

  // kind: 0 legal, 1 zero length, 2 out of range, 3 misaligned
  task automatic run_req(input int addr, input int len, input int ps, input int sh,
                         input int gap, input bit intrude);
    int kind, got_done, got_err, waitc;
    if (len == 0) kind = 1;
    else if (addr + len > 64 * ps) kind = 2;
    else if ((addr % ps) != 0 || (len % ps) != 0) kind = 3;
    else kind = 0;
    @(negedge clk);
    tst_clear = 1'b1;
    @(negedge clk);
    tst_clear = 1'b0;
    page_size = PS_W'(ps); page_shift = SH_W'(sh); poll_gap = GAP_W'(gap);
    dev_size = ADDR_W'(64 * ps);
    req_addr = ADDR_W'(addr); req_len = ADDR_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (kind == 0) chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
    got_done = int'(done); got_err = int'(error); waitc = 0;
    while (!done && !error && waitc < 40000) begin
      if (intrude && waitc == 30) begin
        req_addr = '0; req_len = '0; req_valid = 1'b1;
      end
      @(negedge clk);
      req_valid = 1'b0;
      waitc++;
      got_done = int'(done); got_err = int'(error);
    end
    if (kind == 1) chk(waitc == 0, "R1 done latency", waitc, 0);
    chk(got_done == ((kind == 0 || kind == 1) ? 1 : 0), req_tag(kind), got_done,
        (kind == 0 || kind == 1) ? 1 : 0);
    chk(got_err == ((kind == 2 || kind == 3) ? 1 : 0), req_tag(kind), got_err,
        (kind == 2 || kind == 3) ? 1 : 0);
    @(negedge clk);
    chk(!done && !error, "R9 pulse width", int'(done | error), 0);
    repeat (4) @(negedge clk);
    if (kind != 0) begin
      chk(nbytes == 0, {req_tag(kind), " no SPI traffic"}, nbytes, 0);
    end else begin
      build_exp(addr / ps, len / ps, sh);
      chk(nframes == exp_n, "R6 frame count", nframes, exp_n);
      for (int i = 0; i < exp_n && i < nframes; i++) begin
        chk(rec_op[i] == exp_op[i], "R5 opcode", int'(rec_op[i]), int'(exp_op[i]));
        chk(rec_b1[i] == exp_b1[i] && rec_b2[i] == exp_b2[i] && rec_b3[i] == 8'h00,
            "R4 address bytes", int'({rec_b1[i], rec_b2[i], rec_b3[i]}),
            int'({exp_b1[i], exp_b2[i], 8'h00}));
      end
      chk(viol_busy == 0, "R7 ready before next step", viol_busy, 0);
      chk(viol_gap == 0, "R8 poll gap", viol_gap, 0);
      chk(ndone == 1, intrude ? "R10 single done" : "R9 single done", ndone, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !error && !spi_cs && !spi_req, "R9 reset state",
        int'({busy, done, error, spi_cs, spi_req}), 0);
    chk(spi_cs == 1'b0, "R11 idle chip select", int'(spi_cs), 0);
    // directed corners
    run_req(5 * 264, 0, 264, 9, 2, 1'b0);            // R1
    run_req(60 * 264, 5 * 264, 264, 9, 1, 1'b0);     // R2 over by one page
    run_req(56 * 264, 8 * 264, 264, 9, 1, 1'b0);     // R2 exact end legal
    run_req(3 * 264 + 7, 264, 264, 9, 1, 1'b0);      // R3 address
    run_req(3 * 264, 264 + 1, 264, 9, 1, 1'b0);      // R3 length
    run_req(8 * 256, 8 * 256, 256, 8, 0, 1'b0);      // R5 one block
    run_req(7 * 256, 9 * 256, 256, 8, 3, 1'b0);      // R5 page then block
    run_req(8 * 264, 7 * 264, 264, 9, 0, 1'b0);      // R5 seven pages
    run_req(0, 64 * 264, 264, 9, 5, 1'b0);           // R6 whole device
    run_req(2 * 264, 20 * 264, 264, 9, 2, 1'b1);     // R10 intrusion
    // random mix
    for (int t = 0; t < 30; t++) begin
      automatic int ps   = ($urandom % 2) ? 264 : 256;
      automatic int sh   = (ps == 264) ? 9 : 8;
      automatic int p    = int'($urandom % 64);
      automatic int n    = 1 + int'($urandom % (64 - p));
      automatic int mode = int'($urandom % 6);
      case (mode)
        0: run_req(p * ps, 0, ps, sh, int'($urandom % 4), 1'b0);
        1: run_req(p * ps, (65 - p) * ps, ps, sh, 1, 1'b0);
        2: run_req(p * ps + 1 + int'($urandom % 7), n * ps, ps, sh, 1, 1'b0);
        default: run_req(p * ps, n * ps, ps, sh, int'($urandom % 6), mode == 5);
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 190000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule